// File: doc/BRIEF.md
# Serial Interface Signal Multiplexer

This block carries the control and data lines of an asynchronous serial port across a time-division switch. The block treats the whole line bundle as a two-channel serial stream. Once per frame it samples every incoming interface line and pads the result to sixteen bits. The first eight bits form channel 0 and the next eight form channel 1. It shifts the sixteen bits out at the bit clock. In the other direction it collects a sixteen-bit frame from the switch. It drives its outgoing interface lines from the data bits of that frame and discards the filler.

One frame strobe serves two purposes: it is the sampling instant and it is the switch frame sync, so the bundle always occupies the first two channels of the switch frame. A role parameter picks which side of the link the block faces. Facing the DCE, it samples 13 lines and drives 8. Facing the DTE, it samples 8 lines and drives 13. Interface inputs are asynchronous and pass through a two-flop synchronizer. The serial stream runs at a fixed rate with no back-pressure: a bit is due in every bit clock and none can be held back, so the stream ports carry no valid/ready pair.

Top module: `sig_bundle_mux`

## Requirements
- R1: While reset is asserted and until the first frame strobe, `ser_out` is 1 and every bit of `sig_out` is 0.
- R2: On a clock edge where `frame_sync` is 1, the block loads its sample. During the bit period after that edge, `ser_out` carries frame bit 0, and bit k follows k periods later. Frame bit k is sampled `sig_in[IN_W-1-k]` for k < IN_W, so the most significant line goes first. Frame bits 0 to 7 form channel 0 and bits 8 to 15 form channel 1.
- R3: Frame bits IN_W to 15 are filler and are sent as 1.
- R4: After frame bit 15, `ser_out` stays at 1 until the next strobe.
- R5: A frame carries the value that `sig_in` held at the clock edge two edges before the strobe edge. A change made after that edge does not appear in that frame.
- R6: The value of `ser_in` at the (k+1)-th edge after the strobe edge is received frame bit k, and `sig_out[OUT_W-1-j]` takes received bit j. All bits of `sig_out` change together at the 16th edge after the strobe edge, and this still holds when that edge carries the next strobe.
- R7: Between those update edges `sig_out` holds its value, and a frame that is still arriving never shows up partly.
- R8: Received frame bits OUT_W to 15 are filler and have no effect on `sig_out`.
- R9: A strobe before the current frame has ended restarts both directions. The partly received frame is dropped and `sig_out` keeps its old value. The new sample is sent from frame bit 0.
- R10: With `ROLE` = FACE_DCE (0), IN_W is 13 and OUT_W is 8. With `ROLE` = FACE_DTE (1), IN_W is 8 and OUT_W is 13. A frame is always 16 bits long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one serial bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_sync | input | 1 | One-cycle frame strobe, doubles as sampling instant |
| sig_in | input | IN_W (13 or 8) | Asynchronous interface lines to be carried |
| ser_out | output | 1 | Serial stream toward the switch |
| ser_in | input | 1 | Serial stream from the switch, aligned to the same strobe |
| sig_out | output | OUT_W (8 or 13) | Interface lines rebuilt from the received frame |

## Verification
The transmitted bit k is due in the bit period that starts k edges after the strobe edge, so the bench reads `ser_out` at the falling edge that follows each of those edges. It drives `ser_in` at the same falling edges, and it expects `sig_out` to change only after the 16th rising edge past the strobe. On every one of the 16 intermediate falling edges it confirms that the old value is still present. Sampling latency is exercised by setting interface lines three edges ahead of the strobe and then changing them between the second and the first edge before it, where the new value must not appear. Both roles are instantiated side by side, and every expected frame is built from the requirement's bit order.

// File: rtl/slm_pkg.sv
package slm_pkg;

  // Bits carried per sampling period: two switch channels of eight bits.
  localparam int FRAME_BITS = 16;

  typedef enum logic {
    FACE_DCE = 1'b0,   // wide input bundle, narrow output bundle
    FACE_DTE = 1'b1    // narrow input bundle, wide output bundle
  } role_e;

  function automatic int lines_in(role_e r);
    return (r == FACE_DCE) ? 13 : 8;
  endfunction

  function automatic int lines_out(role_e r);
    return (r == FACE_DCE) ? 8 : 13;
  endfunction

endpackage

// File: rtl/slm_sync.sv
module slm_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= din;
      stab_q <= meta_q;
    end
  end

  assign dout = stab_q;

endmodule

// File: rtl/slm_ser.sv
module slm_ser
  import slm_pkg::*;
#(
  parameter int IN_W = 13,
  parameter int FB   = FRAME_BITS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_sync,
  input  logic [IN_W-1:0] sample,
  output logic            ser_out
);

  localparam int PAD_W = FB - IN_W;
  localparam int AW    = $clog2(FB + 1);

  logic [FB-1:0] load_word;
  logic [FB-1:0] shreg;

  // Filler sits after the data bits and is sent as ones.
  generate
    if (PAD_W > 0) begin : g_pad
      assign load_word = {sample, {PAD_W{1'b1}}};
    end else begin : g_nopad
      assign load_word = sample;
    end
  endgenerate

  // Shifting in ones leaves the line high once the frame has gone out.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '1;
    end else if (frame_sync) begin
      shreg <= load_word;
    end else begin
      shreg <= {shreg[FB-2:0], 1'b1};
    end
  end

  assign ser_out = shreg[FB-1];

  // Position of the bit now on the line; FB means no frame in flight.
  logic [AW-1:0] bit_age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_age <= AW'(FB);
    end else if (frame_sync) begin
      bit_age <= '0;
    end else if (bit_age != AW'(FB)) begin
      bit_age <= bit_age + 1'b1;
    end
  end

  AST_FIRST_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync |=> (ser_out == $past(sample[IN_W-1]))); // R2

  AST_PAD_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    ((int'(bit_age) >= IN_W) && (int'(bit_age) < FB)) |-> ser_out); // R3

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_age == AW'(FB)) |-> ser_out); // R4

endmodule

// File: rtl/slm_deser.sv
module slm_deser
  import slm_pkg::*;
#(
  parameter int OUT_W = 8,
  parameter int FB    = FRAME_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_sync,
  input  logic             ser_in,
  output logic [OUT_W-1:0] par_out
);

  localparam int CW = $clog2(FB);

  logic [CW-1:0]    bit_cnt;
  logic             active;
  logic [OUT_W-1:0] shadow;
  logic [OUT_W-1:0] shadow_next;
  logic             data_bit;
  logic             last_bit;

  assign data_bit    = active && (int'(bit_cnt) < OUT_W);
  assign last_bit    = active && (bit_cnt == CW'(FB - 1));
  assign shadow_next = {shadow[OUT_W-2:0], ser_in};

  // Frame position: a strobe always restarts at bit 0.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      active  <= 1'b0;
    end else if (frame_sync) begin
      bit_cnt <= '0;
      active  <= 1'b1;
    end else if (last_bit) begin
      active  <= 1'b0;
    end else if (active) begin
      bit_cnt <= bit_cnt + 1'b1;
    end
  end

  // Only data bits enter the shadow; filler bits fall through unused.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow <= '0;
    end else if (data_bit) begin
      shadow <= shadow_next;
    end
  end

  // All outputs move together on the last bit of a complete frame.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_out <= '0;
    end else if (last_bit) begin
      par_out <= (OUT_W == FB) ? shadow_next : shadow;
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !last_bit |=> $stable(par_out)); // R7

endmodule

// File: rtl/sig_bundle_mux.sv
module sig_bundle_mux
  import slm_pkg::*;
#(
  parameter role_e ROLE  = FACE_DCE,
  localparam int   IN_W  = lines_in(ROLE),
  localparam int   OUT_W = lines_out(ROLE)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_sync,
  input  logic [IN_W-1:0]  sig_in,
  output logic             ser_out,
  input  logic             ser_in,
  output logic [OUT_W-1:0] sig_out
);

  logic [IN_W-1:0] sig_sync;

  slm_sync #(.W(IN_W)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (sig_in),
    .dout (sig_sync)
  );

  slm_ser #(.IN_W(IN_W), .FB(FRAME_BITS)) u_ser (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_sync(frame_sync),
    .sample    (sig_sync),
    .ser_out   (ser_out)
  );

  slm_deser #(.OUT_W(OUT_W), .FB(FRAME_BITS)) u_deser (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_sync(frame_sync),
    .ser_in    (ser_in),
    .par_out   (sig_out)
  );

  AST_ROLE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (IN_W + OUT_W) == 21 && IN_W <= FRAME_BITS && OUT_W <= FRAME_BITS); // R10

endmodule

// File: tb/sig_bundle_mux_tb.sv
module sig_bundle_mux_tb;
  import slm_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fs = 1'b0;
  logic [12:0] a_in = '0;
  logic        a_ser_out;
  logic        a_ser_in = 1'b1;
  logic [7:0]  a_out;
  logic [7:0]  b_in = '0;
  logic        b_ser_out;
  logic        b_ser_in = 1'b1;
  logic [12:0] b_out;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [7:0]  exp_a = '0;
  logic [12:0] exp_b = '0;

  always #10 clk = ~clk;

  sig_bundle_mux #(.ROLE(FACE_DCE)) u_dut (
    .clk(clk), .rst_n(rst_n), .frame_sync(fs), .sig_in(a_in),
    .ser_out(a_ser_out), .ser_in(a_ser_in), .sig_out(a_out)
  );

  sig_bundle_mux #(.ROLE(FACE_DTE)) u_dut_dte (
    .clk(clk), .rst_n(rst_n), .frame_sync(fs), .sig_in(b_in),
    .ser_out(b_ser_out), .ser_in(b_ser_in), .sig_out(b_out)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp_v);
    end
  endtask

  // One full frame: inputs set three edges ahead, late values at the edge
  // that must be excluded (R5), 16 bits driven in and read out.
  task automatic run_frame(input logic [12:0] a_v, input logic [12:0] a_late,
                           input logic [7:0] b_v, input logic [7:0] b_late,
                           input logic [15:0] rxa, input logic [15:0] rxb,
                           input string req);
    logic [15:0] capa;
    logic [15:0] capb;
    int hold_err;
    hold_err = 0;
    @(negedge clk);
    a_in = a_v;
    b_in = b_v;
    repeat (2) @(negedge clk);
    a_in = a_late;
    b_in = b_late;
    @(negedge clk);
    fs = 1'b1;
    @(negedge clk);
    fs = 1'b0;
    for (int k = 0; k < 16; k++) begin
      a_ser_in = rxa[15-k];
      b_ser_in = rxb[15-k];
      capa[15-k] = a_ser_out;
      capb[15-k] = b_ser_out;
      if (a_out !== exp_a || b_out !== exp_b) hold_err++;
      @(negedge clk);
    end
    // R2 R3: data MSB first, filler ones
    chk(capa === {a_v, 3'b111}, {req, " R2/R3 tx wide"}, 32'(capa),
        32'({a_v, 3'b111}));
    chk(capb === {b_v, 8'hFF}, {req, " R10 R3 tx narrow"}, 32'(capb),
        32'({b_v, 8'hFF}));
    chk(hold_err == 0, {req, " R7 outputs held during reception"},
        32'(hold_err), 32'd0);
    exp_a = rxa[15:8];
    exp_b = rxb[15:3];
    chk(a_out === exp_a, {req, " R6 rx narrow"}, 32'(a_out), 32'(exp_a));
    chk(b_out === exp_b, {req, " R10 R6 rx wide"}, 32'(b_out), 32'(exp_b));
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(a_ser_out === 1'b1 && b_ser_out === 1'b1, "R1 line high in reset",
        32'({a_ser_out, b_ser_out}), 32'h3);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(a_out === '0 && b_out === '0, "R1 outputs zero",
        32'({a_out, b_out}), 32'd0);
    chk(a_ser_out === 1'b1 && b_ser_out === 1'b1, "R1 line high after reset",
        32'({a_ser_out, b_ser_out}), 32'h3);
  endtask

  task automatic t_idle();
    int low;
    low = 0;
    for (int k = 0; k < 6; k++) begin
      if (a_ser_out !== 1'b1 || b_ser_out !== 1'b1) low++;
      @(negedge clk);
    end
    chk(low == 0, "R4 line idles high", 32'(low), 32'd0);
  endtask

  task automatic t_filler();
    // R8: same data bits, filler all 0 then all 1
    run_frame(13'h0AAA, 13'h0AAA, 8'h3C, 8'h3C, 16'h3C00, 16'h9AB0, "R8 f0");
    run_frame(13'h0AAA, 13'h0AAA, 8'h3C, 8'h3C, 16'h3CFF, 16'h9AB7, "R8 f1");
    chk(a_out === 8'h3C && b_out === 13'h1356, "R8 filler ignored",
        32'({a_out, b_out}), 32'({8'h3C, 13'h1356}));
  endtask

  task automatic t_late();
    // R5: change two edges or fewer before the strobe is not sent
    run_frame(13'h0F0F, 13'h10F0, 8'h55, 8'hAA, 16'h1234, 16'h8765, "R5 late");
  endtask

  task automatic t_restart();
    logic [7:0]  old_a;
    logic [12:0] old_b;
    old_a = a_out;
    old_b = b_out;
    @(negedge clk);
    fs = 1'b1;
    @(negedge clk);
    fs = 1'b0;
    for (int k = 0; k < 5; k++) begin
      a_ser_in = ~a_ser_in;
      b_ser_in = 1'b0;
      @(negedge clk);
    end
    // R9: frame cut short, new one follows within 16 bits
    run_frame(13'h1234, 13'h1234, 8'h99, 8'h99, 16'hC3A5, 16'h5AC3, "R9 restart");
    chk(old_a !== 8'hC3 || old_b !== 13'h0B58, "R9 outputs changed by new frame",
        32'({old_a, old_b}), 32'h0);
  endtask

  initial begin
    t_reset();
    run_frame(13'h1A5C, 13'h1A5C, 8'hC3, 8'hC3, 16'h5A3C, 16'hF0F7, "R2 basic");
    t_idle();
    run_frame(13'h0000, 13'h0000, 8'h00, 8'h00, 16'h0000, 16'h0000, "R3 zeros");
    run_frame(13'h1FFF, 13'h1FFF, 8'hFF, 8'hFF, 16'hFFFF, 16'hFFFF, "R6 ones");
    t_filler();
    t_late();
    t_idle();
    t_restart();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule